// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

A bank of small control registers for an I/O companion device. It holds a configuration byte, a diagnostic byte, a modem-control byte, an auxiliary byte whose bit 1 fires a floppy terminal-count strobe, a power-control byte that carries a power-fail flag, a 16-bit LED word and a system-control byte. Several bits have side effects. A write can fire a strobe, clear the power-fail flag, or request a power-off or a system reset.

Each register has its own select line. Every access names a size: byte, halfword or word. A register answers only to an access of its own size at offset 0. The asynchronous power-failing input passes through a synchroniser. Each change of the synchronised level updates the power-fail flag. The interrupt output is high when the flag is set and the interrupt enable is set. Read data is registered.

Top module: `sysctl_bank`

## Requirements
- R1: A legal write to the auxiliary register (select bit 3) with data bit 1 set makes `fd_tc_pulse` high for exactly one cycle, the cycle after the write. The register stores the written byte with bit 1 forced to 0. A write with bit 1 clear makes no pulse.
- R2: A read of the power-control register (select bit 4) returns bit 0 = stored power-off bit, bit 5 = power-fail flag, and all other bits 0. A write stores data bit 0 only.
- R3: A power-control write with data bit 1 set clears the power-fail flag. A power-control write with bit 1 clear leaves the flag unchanged.
- R4: A power-control write with data bit 0 set makes `pwroff_req` high for exactly one cycle, the cycle after the write.
- R5: The power-failing input passes through a two-stage synchroniser. On each change of the synchronised level, the flag takes that level ANDed with configuration bit 3 (the interrupt enable) as it stood before the edge. When the change falls in the same cycle as a clearing write, the change wins.
- R6: `pwr_irq` is a register. It equals the power-fail flag AND configuration bit 3. It follows a configuration write in the cycle after that write, even when the flag does not change.
- R7: Reset clears the configuration, modem-control, auxiliary and power-control registers, including the flag. The diagnostic, LED and system-control registers keep their contents.
- R8: A legal word write to system control (select bit 6) with data bit 0 set stores 0x02 and makes `sysrst_req` high for one cycle. A word write with bit 0 clear changes nothing.
- R9: An access is legal only when all of these hold: exactly one select bit is set, `acc_off` is 0, and `acc_size` matches the register. Size codes are 0 = byte (select bits 0 to 4), 1 = halfword (LED, select bit 5) and 2 = word (select bit 6). An illegal write changes nothing and fires no strobe. An illegal read returns 0.
- R10: `acc_rdata` shows the value of a legal read in the cycle after the access. It is 0 in every other cycle. The configuration (bit 0), diagnostic (bit 1), modem (bit 2) and LED registers read back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 7 | One-hot register select |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_off | input | 2 | Byte offset inside the register window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| pwr_failing_in | input | 1 | Asynchronous power-failing indication |
| pwr_irq | output | 1 | Power-fail interrupt |
| fd_tc_pulse | output | 1 | One-cycle terminal-count strobe |
| pwroff_req | output | 1 | One-cycle power-off request |
| sysrst_req | output | 1 | One-cycle system reset request |

## Verification
Two events can reach the power-fail flag in the same cycle: a synchronised edge of the power-failing input and a clearing write to the power-control register. The bench raises the input and then idles for exactly two cycles. It issues the clearing write on the third cycle, so that the edge reaches the flag detector in the cycle of that write. The reference model applies the edge after the clear, so the flag, the interrupt and a later power-control read must all show the flag set. Configuration writes that toggle the enable while the flag is held check that the interrupt tracks the enable without the flag changing.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
  localparam int NREG = 7;

  // register select indices
  localparam int IDX_CFG   = 0;
  localparam int IDX_DIAG  = 1;
  localparam int IDX_MODEM = 2;
  localparam int IDX_AUX1  = 3;
  localparam int IDX_AUX2  = 4;
  localparam int IDX_LED   = 5;
  localparam int IDX_SYS   = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int CFG_PIE_BIT  = 3;
  localparam int AUX1_TC_BIT  = 1;
  localparam int PWR_OFF_BIT  = 0;
  localparam int PWR_CLR_BIT  = 1;
  localparam int PWR_FLAG_BIT = 5;
  localparam int SYS_RST_BIT  = 0;
  localparam logic [7:0] SYS_STAT_VAL = 8'h02;

  function automatic logic [1:0] reg_size(input int idx);
    if (idx == IDX_LED)      return SZ_HALF;
    else if (idx == IDX_SYS) return SZ_WORD;
    else                     return SZ_BYTE;
  endfunction
endpackage

// File: rtl/sysctl_sync.sv
`timescale 1ns/1ps
module sysctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sysctl_decode.sv
`timescale 1ns/1ps
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [NREG-1:0] acc_sel,
  input  logic [1:0]      acc_size,
  input  logic [1:0]      acc_off,
  output logic [NREG-1:0] wr_hit,
  output logic [NREG-1:0] rd_hit
);
  logic [NREG-1:0] size_ok;
  logic            single;

  assign single = (|acc_sel) && ((acc_sel & (acc_sel - NREG'(1))) == '0);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign size_ok[g] = acc_sel[g] && (acc_size == reg_size(g)) && (acc_off == 2'd0);
  end

  assign wr_hit = (acc_valid && acc_write && single)  ? size_ok : '0;
  assign rd_hit = (acc_valid && !acc_write && single) ? size_ok : '0;
endmodule

// File: rtl/sysctl_pwr.sv
`timescale 1ns/1ps
module sysctl_pwr #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_failing_in,
  input  logic       en_now,
  input  logic       en_next,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  output logic       off_q,
  output logic       flag_q,
  output logic       irq_q,
  output logic       pwroff_req
);
  logic pf_sync, pf_prev, pf_change, clr_now, flag_d;

  sysctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pwr_failing_in), .q(pf_sync)
  );

  assign pf_change = pf_sync ^ pf_prev;
  assign clr_now   = ctl_wr && ctl_wdata[1];

  // an input edge is applied after a clear in the same cycle
  always_comb begin
    if (pf_change)    flag_d = pf_sync && en_now;
    else if (clr_now) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_prev    <= 1'b0;
      flag_q     <= 1'b0;
      off_q      <= 1'b0;
      irq_q      <= 1'b0;
      pwroff_req <= 1'b0;
    end else begin
      pf_prev    <= pf_sync;
      flag_q     <= flag_d;
      irq_q      <= flag_d && en_next;
      pwroff_req <= ctl_wr && ctl_wdata[0];
      if (ctl_wr) off_q <= ctl_wdata[0];
    end
  end

  assert_irq_tracks_flag_R6: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q && en_now));

  assert_clear_wins_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_now && !pf_change) |=> !flag_q);

  assert_edge_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (pf_change && !en_now) |=> !flag_q);

  assert_pwroff_cause_R4: assert property (@(posedge clk) disable iff (rst)
    pwroff_req |-> $past(ctl_wr && ctl_wdata[0]));
endmodule

// File: rtl/sysctl_bank.sv
`timescale 1ns/1ps
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [NREG-1:0]   acc_sel,
  input  logic [1:0]        acc_size,
  input  logic [1:0]        acc_off,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              pwr_failing_in,
  output logic              pwr_irq,
  output logic              fd_tc_pulse,
  output logic              pwroff_req,
  output logic              sysrst_req
);
  localparam int BW = 8;
  localparam int HW = 16;

  logic [NREG-1:0]   wr_hit, rd_hit;
  logic [BW-1:0]     cfg_q, cfg_d, diag_q, modem_q, aux1_q, sys_q, pwr_view;
  logic [HW-1:0]     led_q;
  logic              off_q, flag_q;
  logic [DATA_W-1:0] rd_val;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^acc_wdata[DATA_W-1:HW];

  sysctl_decode u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
    .acc_size(acc_size), .acc_off(acc_off), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  assign cfg_d = wr_hit[IDX_CFG] ? acc_wdata[BW-1:0] : cfg_q;

  sysctl_pwr #(.SYNC_STAGES(SYNC_STAGES)) u_pwr (
    .clk(clk), .rst(rst), .pwr_failing_in(pwr_failing_in),
    .en_now(cfg_q[CFG_PIE_BIT]), .en_next(cfg_d[CFG_PIE_BIT]),
    .ctl_wr(wr_hit[IDX_AUX2]), .ctl_wdata(acc_wdata[1:0]),
    .off_q(off_q), .flag_q(flag_q), .irq_q(pwr_irq), .pwroff_req(pwroff_req)
  );

  // registers cleared by reset, plus the strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      modem_q     <= '0;
      aux1_q      <= '0;
      fd_tc_pulse <= 1'b0;
      sysrst_req  <= 1'b0;
    end else begin
      cfg_q       <= cfg_d;
      if (wr_hit[IDX_MODEM]) modem_q <= acc_wdata[BW-1:0];
      if (wr_hit[IDX_AUX1])
        aux1_q <= acc_wdata[BW-1:0] & ~(BW'(1) << AUX1_TC_BIT);
      fd_tc_pulse <= wr_hit[IDX_AUX1] && acc_wdata[AUX1_TC_BIT];
      sysrst_req  <= wr_hit[IDX_SYS] && acc_wdata[SYS_RST_BIT];
    end
  end

  // registers that survive reset
  always_ff @(posedge clk) begin
    if (wr_hit[IDX_DIAG]) diag_q <= acc_wdata[BW-1:0];
    if (wr_hit[IDX_LED])  led_q  <= acc_wdata[HW-1:0];
    if (wr_hit[IDX_SYS] && acc_wdata[SYS_RST_BIT]) sys_q <= SYS_STAT_VAL;
  end

  always_comb begin
    pwr_view               = '0;
    pwr_view[PWR_OFF_BIT]  = off_q;
    pwr_view[PWR_FLAG_BIT] = flag_q;
  end

  always_comb begin
    rd_val = '0;
    if (rd_hit[IDX_CFG])   rd_val = DATA_W'(cfg_q);
    if (rd_hit[IDX_DIAG])  rd_val = DATA_W'(diag_q);
    if (rd_hit[IDX_MODEM]) rd_val = DATA_W'(modem_q);
    if (rd_hit[IDX_AUX1])  rd_val = DATA_W'(aux1_q);
    if (rd_hit[IDX_AUX2])  rd_val = DATA_W'(pwr_view);
    if (rd_hit[IDX_LED])   rd_val = DATA_W'(led_q);
    if (rd_hit[IDX_SYS])   rd_val = DATA_W'(sys_q);
  end

  always_ff @(posedge clk) begin
    if (rst) acc_rdata <= '0;
    else     acc_rdata <= rd_val;
  end

  assert_tc_cause_R1: assert property (@(posedge clk) disable iff (rst)
    fd_tc_pulse |-> $past(wr_hit[IDX_AUX1] && acc_wdata[AUX1_TC_BIT]));

  assert_aux1_tc_bit_low_R1: assert property (@(posedge clk) disable iff (rst)
    $past(wr_hit[IDX_AUX1]) |-> !aux1_q[AUX1_TC_BIT]);

  assert_sysrst_status_R8: assert property (@(posedge clk) disable iff (rst)
    sysrst_req |-> (sys_q == SYS_STAT_VAL));

  assert_single_hit_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit | rd_hit));

  assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(|rd_hit) |-> (acc_rdata == '0));
endmodule

// File: tb/sysctl_bank_bench.sv
`timescale 1ns/1ps
module sysctl_bank_bench;
  import sysctl_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [6:0]  acc_sel = '0;
  logic [1:0]  acc_size = '0, acc_off = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        pwr_failing_in = 1'b0;
  logic        pwr_irq, fd_tc_pulse, pwroff_req, sysrst_req;

  always #10 clk = ~clk;

  sysctl_bank u_sysctl_bank (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sel(acc_sel), .acc_size(acc_size), .acc_off(acc_off),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .pwr_failing_in(pwr_failing_in), .pwr_irq(pwr_irq),
    .fd_tc_pulse(fd_tc_pulse), .pwroff_req(pwroff_req), .sysrst_req(sysrst_req)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_cfg, m_diag, m_modem, m_aux1, m_led, m_sys, m_off, m_flag;
  int e_irq, e_tc, e_poff, e_srst;
  int unsigned e_rd;
  int pf_hist[$];

  function automatic int want_size(input int idx);
    case (idx)
      5: return 1;
      6: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned model_read(input int idx);
    case (idx)
      0: return m_cfg;
      1: return m_diag;
      2: return m_modem;
      3: return m_aux1;
      4: return (m_flag << 5) | m_off;
      5: return m_led;
      default: return m_sys;
    endcase
  endfunction

  task automatic model_edge();
    int nsel = 0, idx = -1, old_cfg = m_cfg, wd = int'(acc_wdata), synced;
    bit legal, clr = 0, chg;
    if (rst) begin
      m_cfg = 0; m_modem = 0; m_aux1 = 0; m_off = 0; m_flag = 0;
      e_irq = 0; e_tc = 0; e_poff = 0; e_srst = 0; e_rd = 0;
      pf_hist = '{0, 0, 0};
      return;
    end
    for (int i = 0; i < 7; i++) if (acc_sel[i]) begin nsel++; idx = i; end
    legal = acc_valid && nsel == 1 && acc_off == 0 && int'(acc_size) == want_size(idx);
    e_tc = 0; e_poff = 0; e_srst = 0; e_rd = 0;
    synced = pf_hist[1];
    chg = pf_hist[1] != pf_hist[2];
    if (legal && !acc_write) e_rd = model_read(idx);
    if (legal && acc_write) begin
      case (idx)
        0: m_cfg = wd & 255;
        1: m_diag = wd & 255;
        2: m_modem = wd & 255;
        3: begin m_aux1 = wd & 8'hFD; e_tc = (wd >> 1) & 1; end
        4: begin m_off = wd & 1; e_poff = wd & 1; clr = ((wd >> 1) & 1) == 1; end
        5: m_led = wd & 16'hFFFF;
        default: if ((wd & 1) == 1) begin m_sys = 2; e_srst = 1; end
      endcase
    end
    if (chg) m_flag = (synced != 0 && ((old_cfg >> 3) & 1) == 1) ? 1 : 0;
    else if (clr) m_flag = 0;
    e_irq = (m_flag == 1 && ((m_cfg >> 3) & 1) == 1) ? 1 : 0;
    pf_hist.push_front(int'(pwr_failing_in));
    void'(pf_hist.pop_back());
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic step(input string rtag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    check("R6 irq", {31'd0, pwr_irq}, e_irq);
    check("R1 tc pulse", {31'd0, fd_tc_pulse}, e_tc);
    check("R4 power-off request", {31'd0, pwroff_req}, e_poff);
    check("R8 reset request", {31'd0, sysrst_req}, e_srst);
    check(rtag, acc_rdata, e_rd);
  endtask

  task automatic idle(input string tag);
    acc_valid = 0; acc_write = 0; acc_sel = '0;
    step(tag);
  endtask

  task automatic access(input bit w, input logic [6:0] sel, input int sz, input int off,
                        input int unsigned d, input string tag);
    acc_valid = 1; acc_write = w; acc_sel = sel;
    acc_size = 2'(sz); acc_off = 2'(off); acc_wdata = d;
    step(tag);
    acc_valid = 0; acc_write = 0; acc_sel = '0;
  endtask

  task automatic wr(input int idx, input int sz, input int unsigned d, input string tag);
    access(1, 7'(1 << idx), sz, 0, d, tag);
  endtask

  task automatic rd(input int idx, input int sz, input string tag);
    access(0, 7'(1 << idx), sz, 0, 0, tag);
    idle(tag);
  endtask

  initial begin
    rst = 1;
    for (int i = 0; i < 3; i++) idle("R7 in reset");
    rst = 0;
    idle("R7 after reset");
    rd(0, 0, "R7 cfg reset value");
    rd(4, 0, "R7 pwr reset value");
    // plain registers
    wr(0, 0, 32'h000000A5, "R10 cfg write");   rd(0, 0, "R10 cfg readback");
    wr(1, 0, 32'h0000003C, "R10 diag write");  rd(1, 0, "R10 diag readback");
    wr(2, 0, 32'h0000005A, "R10 modem write"); rd(2, 0, "R10 modem readback");
    wr(5, 1, 32'h1234BEEF, "R10 led write");   rd(5, 1, "R10 led readback");
    // terminal count
    wr(3, 0, 32'hFF, "R1 aux all ones"); rd(3, 0, "R1 aux tc bit stored low");
    wr(3, 0, 32'h02, "R1 aux tc only");  rd(3, 0, "R1 aux readback zero");
    wr(3, 0, 32'h01, "R1 aux no tc");    rd(3, 0, "R1 aux bit0");
    wr(3, 0, 32'h02, "R1 back-to-back a"); wr(3, 0, 32'h02, "R1 back-to-back b");
    // power control
    wr(4, 0, 32'hFF, "R2 pwr upper bits dropped"); rd(4, 0, "R2 pwr readback");
    wr(4, 0, 32'h00, "R2 pwr off bit cleared");    rd(4, 0, "R2 pwr readback zero");
    // power fail with enable
    wr(0, 0, 32'h08, "R6 enable");
    pwr_failing_in = 1;
    for (int i = 0; i < 4; i++) idle("R5 flag rises");
    rd(4, 0, "R5 flag visible");
    wr(0, 0, 32'h00, "R6 enable off lowers irq"); rd(4, 0, "R6 flag held");
    wr(0, 0, 32'h08, "R6 enable on raises irq");
    wr(4, 0, 32'h00, "R3 write keeps flag");  rd(4, 0, "R3 flag kept");
    wr(4, 0, 32'h02, "R3 write clears flag"); rd(4, 0, "R3 flag cleared");
    // power fail with enable off
    wr(0, 0, 32'h00, "R5 disable");
    pwr_failing_in = 0; for (int i = 0; i < 4; i++) idle("R5 falling");
    pwr_failing_in = 1; for (int i = 0; i < 4; i++) idle("R5 rising gated");
    rd(4, 0, "R5 gated flag zero");
    // same-cycle edge and clearing write
    wr(0, 0, 32'h08, "R5 enable again");
    pwr_failing_in = 0; for (int i = 0; i < 4; i++) idle("R5 settle low");
    pwr_failing_in = 1; idle("R5 edge in flight"); idle("R5 edge in flight");
    wr(4, 0, 32'h02, "R5 clear meets edge"); rd(4, 0, "R5 edge wins over clear");
    wr(4, 0, 32'h02, "R3 clear after collision"); rd(4, 0, "R3 cleared");
    // system control
    wr(6, 2, 32'h00000001, "R8 sysctl reset"); rd(6, 2, "R8 sysctl status");
    wr(6, 2, 32'hFFFFFFFE, "R8 sysctl bit0 clear"); rd(6, 2, "R8 status kept");
    access(1, 7'h40, 2, 2, 32'h1, "R8 nonzero offset write");
    access(0, 7'h40, 2, 2, 0, "R8 nonzero offset read"); idle("R8 offset read zero");
    // illegal sizes and selects
    wr(5, 0, 32'h0000, "R9 byte write to led"); rd(5, 1, "R9 led unchanged");
    rd(5, 0, "R9 byte read of led zero");
    wr(3, 1, 32'h02, "R9 halfword to aux no tc"); rd(3, 0, "R9 aux unchanged");
    wr(4, 2, 32'h01, "R9 word to pwr no request"); rd(4, 0, "R9 pwr unchanged");
    wr(6, 1, 32'h01, "R9 halfword to sysctl no reset");
    access(1, 7'h03, 0, 0, 32'h77, "R9 two selects ignored"); rd(0, 0, "R9 cfg unchanged");
    access(0, 7'h03, 0, 0, 0, "R9 two selects read"); idle("R9 two selects read zero");
    // reset retention
    wr(2, 0, 32'h11, "R7 modem set"); wr(3, 0, 32'h81, "R7 aux set");
    wr(4, 0, 32'h01, "R7 pwr set");
    rst = 1; idle("R7 reset again"); idle("R7 reset again"); rst = 0;
    rd(0, 0, "R7 cfg cleared");  rd(2, 0, "R7 modem cleared");
    rd(3, 0, "R7 aux cleared");  rd(4, 0, "R7 pwr cleared");
    rd(1, 0, "R7 diag kept");    rd(5, 1, "R7 led kept");
    rd(6, 2, "R7 sysctl kept");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule